// File: doc/BRIEF.md
# Hypervisor Virtual Interrupt Pending Logic

This block keeps the software-injected virtual supervisor interrupt bits that a hypervisor sets for its guest. It also forms the VS-level pending bits that the machine and hypervisor pending views show. Software writes the virtual interrupt register through a CSR port. A second, one-bit port writes the software interrupt bit through the machine pending register. Both ports land in the same storage bit.

The external and timer bits follow a different rule. Their stored copies are only what software wrote. The composed pending view merges each stored bit with hardware sources: the guest external interrupt selected out of the guest pending vector, the platform external line and the platform timer line. A read of the virtual interrupt register never shows those hardware sources.

Top module: `hvip_ctrl`

## Requirements
- R1: Only bits 2 (software), 6 (timer) and 10 (external) of `hvip_rdata_o` and `vs_ip_o` can be 1. All other bits always read 0, whatever is written.
- R2: The software bit has one storage bit. A write through the `mip_ssw` port shows at bit 2 of both `hvip_rdata_o` and `vs_ip_o`.
- R3: `vs_ip_o[10]` is the OR of three sources: the stored external bit, the selected guest external pending bit, and `plat_ext_i`.
- R4: `vs_ip_o[6]` is the OR of the stored timer bit and `plat_tmr_i`.
- R5: `hvip_rdata_o[10]` shows only the value software wrote. `plat_ext_i`, `geip_i` and `vgein_i` have no effect on it.
- R6: `hvip_rdata_o[6]` shows only the value software wrote. `plat_tmr_i` has no effect on it.
- R7: A write to the virtual interrupt register stores `hvip_wdata_i` bits 6 and 10 in that register. It passes bit 2 to the shared software bit.
- R8: A `vgein_i` value k with 1 <= k <= NGEI selects `geip_i[k-1]`. A value of 0, or a value above NGEI, selects nothing, so that source is 0.
- R9: While `rst_ni` is low, all stored bits, including the shared software bit, clear to 0 at once.
- R10: Writes take effect on the rising clock edge on which their enable is high. With no enable high, the stored bits hold.
- R11: Reads are combinational. A change on `plat_ext_i`, `plat_tmr_i`, `geip_i` or `vgein_i` shows on `vs_ip_o` in the same cycle.
- R12: If both ports write in the same cycle, the software bit takes the value from `hvip_wdata_i[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hvip_we_i | input | 1 | Write enable for the virtual interrupt register |
| hvip_wdata_i | input | XLEN | Write data for the virtual interrupt register |
| hvip_rdata_o | output | XLEN | Read value of the virtual interrupt register |
| mip_ssw_we_i | input | 1 | Write enable for the software bit through the machine pending register |
| mip_ssw_wdata_i | input | 1 | Value for that write |
| geip_i | input | NGEI | Guest external pending vector; bit k-1 belongs to guest k |
| vgein_i | input | SEL_W | Guest selector |
| plat_ext_i | input | 1 | Platform VS-level external interrupt line |
| plat_tmr_i | input | 1 | Platform VS-level timer line |
| vs_ip_o | output | XLEN | Composed VS pending bits for the machine and hypervisor views |

## Verification
A write shows on both outputs one rising edge after its enable is sampled. The bench therefore drives each write on a falling edge and checks it on the next falling edge, with the inputs still held. Hardware source inputs reach `vs_ip_o` with no cycle of delay. The directed tests change them between edges and check a nanosecond later, with no clock edge in between. One directed test checks that a pending write has not yet shown before its edge. The isolation of the register read from the hardware sources is checked in the same vectors that set those sources.

// File: rtl/hvip_pkg.sv
package hvip_pkg;
  localparam int unsigned VSSIP_BIT = 2;
  localparam int unsigned VSTIP_BIT = 6;
  localparam int unsigned VSEIP_BIT = 10;
endpackage

// File: rtl/hvip_gei_sel.sv
module hvip_gei_sel #(
  parameter int unsigned NGEI  = 8,
  parameter int unsigned SEL_W = 6
) (
  input  logic [NGEI-1:0]  geip_i,
  input  logic [SEL_W-1:0] vgein_i,
  output logic             hit_o
);
  // k in 1..NGEI picks geip_i[k-1]; 0 and out-of-range match nothing
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < int'(NGEI); k++) begin
      if (vgein_i == SEL_W'(k + 1)) hit_o = geip_i[k];
    end
  end
endmodule

// File: rtl/hvip_regs.sv
module hvip_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hvip_we_i,
  input  logic wd_ssw_i,
  input  logic wd_tmr_i,
  input  logic wd_ext_i,
  input  logic mip_we_i,
  input  logic mip_wd_i,
  output logic ssw_q_o,
  output logic tmr_q_o,
  output logic ext_q_o
);
  // shared software bit: hvip write has priority over mip write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssw_q_o <= 1'b0;
    end else if (hvip_we_i) begin
      ssw_q_o <= wd_ssw_i;
    end else if (mip_we_i) begin
      ssw_q_o <= mip_wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q_o <= 1'b0;
      ext_q_o <= 1'b0;
    end else if (hvip_we_i) begin
      tmr_q_o <= wd_tmr_i;
      ext_q_o <= wd_ext_i;
    end
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hvip_we_i && !mip_we_i) |=> $stable({ssw_q_o, tmr_q_o, ext_q_o}));
  a_r12_hvip_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hvip_we_i |=> (ssw_q_o == $past(wd_ssw_i)));
  a_r2_mip_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hvip_we_i && mip_we_i) |=> (ssw_q_o == $past(mip_wd_i)));
  a_r7_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hvip_we_i |=> (tmr_q_o == $past(wd_tmr_i)) && (ext_q_o == $past(wd_ext_i)));
endmodule

// File: rtl/hvip_ctrl.sv
module hvip_ctrl
  import hvip_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NGEI  = 8,
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hvip_we_i,
  input  logic [XLEN-1:0]  hvip_wdata_i,
  output logic [XLEN-1:0]  hvip_rdata_o,
  input  logic             mip_ssw_we_i,
  input  logic             mip_ssw_wdata_i,
  input  logic [NGEI-1:0]  geip_i,
  input  logic [SEL_W-1:0] vgein_i,
  input  logic             plat_ext_i,
  input  logic             plat_tmr_i,
  output logic [XLEN-1:0]  vs_ip_o
);
  localparam logic [XLEN-1:0] VS_MASK =
    (XLEN'(1) << VSSIP_BIT) | (XLEN'(1) << VSTIP_BIT) | (XLEN'(1) << VSEIP_BIT);
  localparam logic [SEL_W-1:0] NGEI_L = SEL_W'(NGEI);

  logic ssw_q, tmr_q, ext_q, gei_hit;

  hvip_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hvip_we_i (hvip_we_i),
    .wd_ssw_i  (hvip_wdata_i[VSSIP_BIT]),
    .wd_tmr_i  (hvip_wdata_i[VSTIP_BIT]),
    .wd_ext_i  (hvip_wdata_i[VSEIP_BIT]),
    .mip_we_i  (mip_ssw_we_i),
    .mip_wd_i  (mip_ssw_wdata_i),
    .ssw_q_o   (ssw_q),
    .tmr_q_o   (tmr_q),
    .ext_q_o   (ext_q)
  );

  hvip_gei_sel #(.NGEI(NGEI), .SEL_W(SEL_W)) u_gei (
    .geip_i  (geip_i),
    .vgein_i (vgein_i),
    .hit_o   (gei_hit)
  );

  // register view: stored bits only
  always_comb begin
    hvip_rdata_o            = '0;
    hvip_rdata_o[VSSIP_BIT] = ssw_q;
    hvip_rdata_o[VSTIP_BIT] = tmr_q;
    hvip_rdata_o[VSEIP_BIT] = ext_q;
  end

  // pending view: stored bits merged with hardware sources
  always_comb begin
    vs_ip_o            = '0;
    vs_ip_o[VSSIP_BIT] = ssw_q;
    vs_ip_o[VSTIP_BIT] = tmr_q | plat_tmr_i;
    vs_ip_o[VSEIP_BIT] = ext_q | gei_hit | plat_ext_i;
  end

  a_r1_ro_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hvip_rdata_o & ~VS_MASK) == '0) && ((vs_ip_o & ~VS_MASK) == '0));
  a_r2_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hvip_rdata_o[VSSIP_BIT] == vs_ip_o[VSSIP_BIT]);
  a_r3_ext_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_ip_o[VSEIP_BIT] == (hvip_rdata_o[VSEIP_BIT] | gei_hit | plat_ext_i));
  a_r4_tmr_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_ip_o[VSTIP_BIT] == (hvip_rdata_o[VSTIP_BIT] | plat_tmr_i));
  a_r5_ext_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hvip_we_i |=> $stable(hvip_rdata_o[VSEIP_BIT]));
  a_r6_tmr_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hvip_we_i |=> $stable(hvip_rdata_o[VSTIP_BIT]));
  a_r8_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vgein_i == '0) || (vgein_i > NGEI_L)) |-> !gei_hit);
endmodule

// File: tb/hvip_ctrl_tb.sv
`timescale 1ns/1ps
module hvip_ctrl_tb_top;
  localparam int XLEN = 64;
  localparam int NGEI = 8;
  localparam int SEL_W = 6;
  localparam int NV = 13;

  typedef struct packed {
    logic        we;
    logic [15:0] wd;
    logic        mwe;
    logic        mwd;
    logic [7:0]  geip;
    logic [5:0]  vgein;
    logic        pe;
    logic        pt;
    logic [15:0] exp_rd;
    logic [15:0] exp_ip;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'hFFFF, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0444, 16'h0444}, // R7 R1
    '{1'b1, 16'h0000, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R7
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 6'd0, 1'b1, 1'b0, 16'h0000, 16'h0400}, // R3 R5
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b1, 16'h0000, 16'h0040}, // R4 R6
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'h08, 6'd4, 1'b0, 1'b0, 16'h0000, 16'h0400}, // R8 R5
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'h08, 6'd3, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R8
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'hFF, 6'd0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R8
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'hFF, 6'd9, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R8
    '{1'b0, 16'h0000, 1'b0, 1'b0, 8'hFF, 6'd8, 1'b0, 1'b0, 16'h0000, 16'h0400}, // R8
    '{1'b0, 16'h0000, 1'b1, 1'b1, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0004, 16'h0004}, // R2
    '{1'b1, 16'h0040, 1'b0, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0040, 16'h0040}, // R7
    '{1'b1, 16'h0004, 1'b1, 1'b0, 8'h00, 6'd0, 1'b0, 1'b0, 16'h0004, 16'h0004}, // R12
    '{1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 6'd0, 1'b1, 1'b1, 16'h0000, 16'h0440}  // R2 R5 R6
  };
  string vreq [NV] = '{"R7/R1", "R7", "R3/R5", "R4/R6", "R8/R5", "R8", "R8", "R8",
                       "R8", "R2", "R7", "R12", "R2/R5/R6"};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hvip_we = 1'b0, mwe = 1'b0, mwd = 1'b0, pe = 1'b0, pt = 1'b0;
  logic [XLEN-1:0] wd = '0, rd, ip;
  logic [NGEI-1:0] geip = '0;
  logic [SEL_W-1:0] vgein = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hvip_ctrl #(.XLEN(XLEN), .NGEI(NGEI), .SEL_W(SEL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hvip_we_i(hvip_we), .hvip_wdata_i(wd),
    .hvip_rdata_o(rd), .mip_ssw_we_i(mwe), .mip_ssw_wdata_i(mwd),
    .geip_i(geip), .vgein_i(vgein), .plat_ext_i(pe), .plat_tmr_i(pt), .vs_ip_o(ip)
  );

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    chk("R9", "reset rd", rd, '0);
    chk("R9", "reset ip", ip, '0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      hvip_we = VECS[i].we; wd = XLEN'(VECS[i].wd);
      mwe = VECS[i].mwe; mwd = VECS[i].mwd;
      geip = VECS[i].geip; vgein = VECS[i].vgein;
      pe = VECS[i].pe; pt = VECS[i].pt;
      @(posedge clk); @(negedge clk);
      chk(vreq[i], $sformatf("vec%0d rd", i), rd, XLEN'(VECS[i].exp_rd));
      chk(vreq[i], $sformatf("vec%0d ip", i), ip, XLEN'(VECS[i].exp_ip));
    end
    hvip_we = 1'b0; mwe = 1'b0; pe = 1'b0; pt = 1'b0; geip = '0; vgein = '0;
    // R1: full-width write keeps only the three bits
    hvip_we = 1'b1; wd = '1;
    @(posedge clk); @(negedge clk);
    chk("R1", "all-ones rd", rd, 64'h444);
    chk("R1", "all-ones ip", ip, 64'h444);
    // R10: a write is not visible before its edge
    wd = 64'h400;
    #1 chk("R10", "pre-edge rd", rd, 64'h444);
    @(posedge clk); @(negedge clk);
    hvip_we = 1'b0;
    chk("R10", "post-edge rd", rd, 64'h400);
    // R11: platform inputs show in the same cycle
    pt = 1'b1;
    #1 chk("R11", "comb tmr ip", ip, 64'h440);
    chk("R6", "tmr hidden rd", rd, 64'h400);
    geip = 8'h01; vgein = 6'd1;
    #1 chk("R11", "comb gei ip", ip, 64'h440);
    pt = 1'b0;
    #1 chk("R11", "comb tmr off ip", ip, 64'h400);
    // R9: asynchronous reset mid-run clears everything, incl. shared bit
    @(negedge clk);
    mwe = 1'b1; mwd = 1'b1; geip = '0; vgein = '0;
    @(posedge clk); @(negedge clk);
    mwe = 1'b0;
    chk("R2", "mip set rd", rd, 64'h404);
    #1 rst_ni = 1'b0;
    #1 chk("R9", "async reset rd", rd, '0);
    chk("R9", "async reset ip", ip, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule